// File: doc/BRIEF.md
# Rate-Selectable Watchdog Timer

This block is a watchdog counter that runs on the oscillator clock. Software picks a timeout period by writing a 3-bit rate code into a control register. After reset the watchdog is off. The first nonzero rate code turns it on and starts a fresh period.

To keep the system alive, software writes a two-byte key to a separate arm register: 0x55, then 0xAA. A completed key restarts the period. If the period runs out, or the arm register receives a bad key, the block raises a single-cycle system reset request. It then returns itself to the disabled state.

The rate and window-enable fields follow extra rules:
- In normal mode they accept only one write after each reset.
- A mask bit in the control write lets software change the stop-in-debug bit alone.
- While a debugger is attached in a special mode, and stop-in-debug is clear, the block ignores the rate code and uses the longest period.

Top module: `wdog_rate_timer`

## Requirements
- R1: After reset, `reset_req` is 0 and `ctl_q` reads 0x00, so the rate code is 000 and the watchdog is disabled. While it is disabled, no timeout occurs.
- R2: Rate codes 1 to 7 select periods of 2^(E-TRIM) cycles, where E is 14, 16, 18, 20, 22, 23 and 24 in code order. `reset_req` rises exactly one period after the clock edge that loaded the code. The counter never goes past the period.
- R3: `reset_req` is high for exactly one cycle. In that same cycle, `ctl_q` shows rate 000 and window-enable 0, and the key state and write-once lock are cleared. Stop-in-debug keeps its value.
- R4: Control register layout: rate in bits 2:0, window-enable in bit 3, stop-in-debug in bit 4, write mask in bit 7. The mask bit reads back as 0. An accepted write of a nonzero rate enables the counter and restarts it from zero.
- R5: Writing 0x55 and then 0xAA to the arm register restarts the period. The next timeout comes one full period after the edge that took in the 0xAA.
- R6: While enabled, an arm write of any value other than 0x55 or 0xAA raises `reset_req` at the edge that takes in that write. So does 0xAA without an earlier 0x55.
- R7: With `special_mode` = 0, only the first unmasked control write after reset (or after a reset request) changes the rate and window-enable fields. Later unmasked writes leave both unchanged and do not restart the count.
- R8: With `special_mode` = 1, every unmasked control write updates the rate and window-enable fields.
- R9: A control write with bit 7 set leaves the rate and window-enable fields unchanged and does not use up the single write. It still updates stop-in-debug.
- R10: When the watchdog is enabled, `dbg_active` = 1, stop-in-debug = 0 and `special_mode` = 1 all hold, the period is 2^(24-TRIM) whatever the rate code is.
- R11: While the watchdog is disabled, arm writes have no effect: no reset request is raised and no key state is recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| arm_wr | input | 1 | Arm register write strobe |
| arm_wdata | input | 8 | Arm register write data (key byte) |
| dbg_active | input | 1 | Debugger active status |
| special_mode | input | 1 | Special or emulation operating mode |
| ctl_q | output | 8 | Control register read value |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The count and the key state are internal, so faults in them surface only through the timing of `reset_req`.

- A counter that restarts at the wrong moment, or compares against the wrong limit, moves the pulse by at least one cycle. Each timeout window is therefore checked cycle by cycle, for early, on-time and stretched pulses.
- A lost half-key state only shows up on the following 0xAA, which then produces an immediate reset request instead of a restart.
- A write-once lock or mask that leaks shows at once in `ctl_q`, and later as a shifted timeout.

The bench mixes directed corners with seeded random rate codes, service points and bad keys.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int unsigned EXP_MAX = 24;

  typedef enum logic {KEY_IDLE, KEY_HALF} key_st_e;

  // Timeout exponent for a rate code, reduced by trim.
  function automatic logic [4:0] rate_exp(input logic [2:0] code, input int unsigned trim);
    int unsigned e;
    case (code)
      3'd1:    e = 14;
      3'd2:    e = 16;
      3'd3:    e = 18;
      3'd4:    e = 20;
      3'd5:    e = 22;
      3'd6:    e = 23;
      3'd7:    e = 24;
      default: e = 24;
    endcase
    return 5'(e - trim);
  endfunction

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       special_mode,
  input  logic       clr,
  output logic [2:0] rate,
  output logic       win_en,
  output logic       dbg_stop,
  output logic       rate_load
);

  localparam int RATE_LSB = 0;
  localparam int WIN_BIT  = 3;
  localparam int STOP_BIT = 4;
  localparam int MASK_BIT = 7;

  logic [2:0] rate_d;
  logic       win_d, stop_d, locked, locked_d;
  logic       field_ok;

  assign field_ok  = wr && !wdata[MASK_BIT] && (special_mode || !locked);
  assign rate_load = field_ok && !clr;

  always_comb begin
    rate_d   = rate;
    win_d    = win_en;
    stop_d   = dbg_stop;
    locked_d = locked;
    if (wr) begin
      stop_d = wdata[STOP_BIT];
    end
    if (field_ok) begin
      rate_d   = wdata[RATE_LSB +: 3];
      win_d    = wdata[WIN_BIT];
      locked_d = 1'b1;
    end
    if (clr) begin
      rate_d   = 3'd0;
      win_d    = 1'b0;
      locked_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate     <= 3'd0;
      win_en   <= 1'b0;
      dbg_stop <= 1'b0;
      locked   <= 1'b0;
    end else begin
      rate     <= rate_d;
      win_en   <= win_d;
      dbg_stop <= stop_d;
      locked   <= locked_d;
    end
  end

  p_write_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata[MASK_BIT] && locked && !special_mode && !clr) |=> (rate == $past(rate)))
    else $error("p_write_once_r7");

  p_mask_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[MASK_BIT] && !clr) |=> (rate == $past(rate) && locked == $past(locked)))
    else $error("p_mask_keeps_r9");

endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_wr,
  input  logic [7:0] arm_wdata,
  input  logic       enabled,
  input  logic       clr,
  output logic       service,
  output logic       fault
);

  key_st_e st, st_d;
  logic    take;

  assign take = arm_wr && enabled;

  always_comb begin
    st_d    = st;
    service = 1'b0;
    fault   = 1'b0;
    if (take) begin
      if (arm_wdata == KEY_FIRST) begin
        st_d = KEY_HALF;
      end else if (arm_wdata == KEY_SECOND && st == KEY_HALF) begin
        st_d    = KEY_IDLE;
        service = 1'b1;
      end else begin
        st_d  = KEY_IDLE;
        fault = 1'b1;
      end
    end
    if (clr) begin
      st_d = KEY_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= KEY_IDLE;
    else        st <= st_d;
  end

  p_orphan_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && arm_wdata == KEY_SECOND && st == KEY_IDLE) |-> fault)
    else $error("p_orphan_second_r6");

  p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && st == KEY_IDLE) |=> (st == KEY_IDLE))
    else $error("p_idle_when_off_r11");

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CW = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enabled,
  input  logic       restart,
  input  logic       clr,
  input  logic [4:0] exp_sel,
  output logic       hit
);

  logic [CW-1:0] cnt, cnt_d, lim;

  assign lim = (CW'(1) << exp_sel) - CW'(1);
  assign hit = enabled && (cnt >= lim);

  always_comb begin
    if (clr || restart || !enabled) cnt_d = '0;
    else if (hit)                   cnt_d = cnt;
    else                            cnt_d = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  p_off_is_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> (cnt == '0))
    else $error("p_off_is_zero_r1");

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == '0))
    else $error("p_cnt_bound_r2");

endmodule

// File: rtl/wdog_rate_timer.sv
module wdog_rate_timer
  import wdog_pkg::*;
#(
  parameter int unsigned TRIM = 0
) (
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       arm_wr,
  input  logic [7:0] arm_wdata,
  input  logic       dbg_active,
  input  logic       special_mode,
  output logic [7:0] ctl_q,
  output logic       reset_req
);

  localparam int unsigned CW      = EXP_MAX - TRIM;
  localparam logic [4:0]  EXP_TOP = 5'(CW);

  logic [2:0] rate;
  logic       win_en, dbg_stop, rate_load;
  logic       enabled, override, service, fault, hit, fire, req_d;
  logic [4:0] exp_sel;
  logic       unused_wdata;

  assign unused_wdata = ^ctl_wdata[6:5];

  assign enabled  = (rate != 3'd0);
  assign override = enabled && dbg_active && !dbg_stop && special_mode;
  assign exp_sel  = override ? EXP_TOP : rate_exp(rate, TRIM);
  assign fire     = hit || fault;

  wdog_ctrl_reg u_ctrl (
    .clk          (clk_osc),
    .rst_n        (rst_n),
    .wr           (ctl_wr),
    .wdata        (ctl_wdata),
    .special_mode (special_mode),
    .clr          (fire),
    .rate         (rate),
    .win_en       (win_en),
    .dbg_stop     (dbg_stop),
    .rate_load    (rate_load)
  );

  wdog_key_seq u_key (
    .clk       (clk_osc),
    .rst_n     (rst_n),
    .arm_wr    (arm_wr),
    .arm_wdata (arm_wdata),
    .enabled   (enabled),
    .clr       (fire),
    .service   (service),
    .fault     (fault)
  );

  wdog_counter #(.CW(CW)) u_cnt (
    .clk     (clk_osc),
    .rst_n   (rst_n),
    .enabled (enabled),
    .restart (rate_load || service),
    .clr     (fire),
    .exp_sel (exp_sel),
    .hit     (hit)
  );

  assign req_d = fire;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) reset_req <= 1'b0;
    else        reset_req <= req_d;
  end

  assign ctl_q = {3'b000, dbg_stop, win_en, rate};

  p_req_pulse_r3: assert property (@(posedge clk_osc) disable iff (!rst_n)
    reset_req |=> !reset_req)
    else $error("p_req_pulse_r3");

  p_req_disables_r3: assert property (@(posedge clk_osc) disable iff (!rst_n)
    reset_req |-> (rate == 3'd0 && !win_en))
    else $error("p_req_disables_r3");

  p_no_fire_off_r11: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !enabled |=> !reset_req)
    else $error("p_no_fire_off_r11");

endmodule

// File: tb/wdog_rate_timer_test.sv
`timescale 1ns/1ps
module wdog_rate_timer_test;

  localparam int unsigned TRIM = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr, arm_wr, dbg_active, special_mode;
  logic [7:0] ctl_wdata, arm_wdata, ctl_q;
  logic       reset_req;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  wdog_rate_timer #(.TRIM(TRIM)) uut (
    .clk_osc(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .arm_wr(arm_wr), .arm_wdata(arm_wdata), .dbg_active(dbg_active),
    .special_mode(special_mode), .ctl_q(ctl_q), .reset_req(reset_req)
  );

  function automatic int period_of(input int code);
    int e;
    case (code)
      1: e = 14; 2: e = 16; 3: e = 18; 4: e = 20;
      5: e = 22; 6: e = 23; default: e = 24;
    endcase
    return 1 << (e - TRIM);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks are entered at a negedge and return at a negedge.
  task automatic ctl_write(input logic [7:0] d);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic arm_write(input logic [7:0] d);
    arm_wr = 1'b1; arm_wdata = d;
    @(negedge clk);
    arm_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Pulse expected exactly p sampling points from now (now = 0).
  task automatic expect_timeout(input int p, input string req);
    int early = -1;
    for (int i = 0; i < p; i++) begin
      if (reset_req && early < 0) early = i;
      @(negedge clk);
    end
    check(early < 0, req, early, p);
    check(reset_req == 1'b1, req, reset_req, 1);
    @(negedge clk);
    check(reset_req == 1'b0, "R3", reset_req, 0);
    check(ctl_q[3:0] == 4'd0, "R3", ctl_q[3:0], 0);
  endtask

  task automatic expect_quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      if (reset_req) seen++;
      @(negedge clk);
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    rst_n = 1'b0; ctl_wr = 1'b0; arm_wr = 1'b0; ctl_wdata = '0; arm_wdata = '0;
    dbg_active = 1'b0; special_mode = 1'b0;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(reset_req == 1'b0, "R1", reset_req, 0);
    check(ctl_q == 8'h00, "R1", ctl_q, 0);
    expect_quiet(40, "R1");

    // R11 arm writes while disabled
    arm_write(8'h12);
    arm_write(8'hAA);
    arm_write(8'h55);
    expect_quiet(5, "R11");
    ctl_write(8'h01);
    arm_write(8'hAA);   // would complete a key only if 0x55 had been recorded
    check(reset_req == 1'b1, "R11", reset_req, 1);
    @(negedge clk);

    // R2 / R4 basic timeout for code 1
    ctl_write(8'h01);
    check(ctl_q == 8'h01, "R4", ctl_q, 1);
    expect_timeout(period_of(1), "R2");

    // R7 write-once in normal mode
    ctl_write(8'h02);
    ctl_write(8'h05);
    check(ctl_q[2:0] == 3'd2, "R7", ctl_q[2:0], 2);
    expect_timeout(period_of(2) - 1, "R7");

    // R9 masked write
    ctl_write(8'h93);
    check(ctl_q == 8'h10, "R9", ctl_q, 8'h10);
    expect_quiet(20, "R9");
    ctl_write(8'h0D);
    check(ctl_q == 8'h0D, "R9", ctl_q, 8'h0D);
    expect_timeout(period_of(5), "R2");
    ctl_write(8'h80);
    check(ctl_q == 8'h00, "R3", ctl_q, 0);

    // R5 service sequence
    ctl_write(8'h01);
    idle(8);
    arm_write(8'h55);
    arm_write(8'hAA);
    expect_timeout(period_of(1), "R5");

    // R6 bad key and orphan second byte
    ctl_write(8'h02);
    arm_write(8'h3C);
    check(reset_req == 1'b1, "R6", reset_req, 1);
    @(negedge clk);
    check(reset_req == 1'b0 && ctl_q == 8'h00, "R3", ctl_q, 0);
    ctl_write(8'h02);
    arm_write(8'hAA);
    check(reset_req == 1'b1, "R6", reset_req, 1);
    @(negedge clk);

    // R8 special mode rewrites
    special_mode = 1'b1;
    ctl_write(8'h03);
    ctl_write(8'h01);
    check(ctl_q[2:0] == 3'd1, "R8", ctl_q[2:0], 1);
    expect_timeout(period_of(1), "R8");

    // R10 debug override
    dbg_active = 1'b1;
    ctl_write(8'h01);
    expect_timeout(period_of(7), "R10");
    ctl_write(8'h11);
    expect_timeout(period_of(1), "R10");
    ctl_write(8'h80);
    dbg_active = 1'b0;
    special_mode = 1'b0;

    // Random mix: service points and bad keys
    for (int it = 0; it < 14; it++) begin
      int code;
      int p;
      int w;
      code = 1 + int'($urandom % 3);
      p = period_of(code);
      w = int'($urandom % (p - 4));
      ctl_write(8'(code));
      check(ctl_q[2:0] == 3'(code), "R4", ctl_q[2:0], code);
      idle(w);
      if ($urandom % 4 == 0) begin
        logic [7:0] v;
        v = 8'($urandom);
        if (v == 8'h55 || v == 8'hAA) v = 8'h00;
        arm_write(v);
        check(reset_req == 1'b1, "R6", reset_req, 1);
        @(negedge clk);
      end else begin
        arm_write(8'h55);
        arm_write(8'hAA);
        expect_timeout(p, "R5");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule